// File: doc/BRIEF.md
# Split-Access Response Reassembler

A memory access that straddles line boundaries is carried as several fragment packets. This block issues those packets, one per fragment and in fragment order, to a memory port that may turn a packet away. It keeps count of the packets in flight and the responses already returned, and it writes each returning fragment into one merged buffer as wide as the whole access. When every fragment has come back, it presents the merged data once.

An access begins with a one-cycle `start_i` pulse that carries the fragment count and the byte offset of the access base within its first line. The packet interface is valid/ready with one difference. If `pkt_valid_o` is high and `pkt_ready_i` is low in the same cycle, that is a refusal. The block then drops `pkt_valid_o` from the next cycle on and offers nothing until a `retry_i` pulse, after which it offers the same index again. Responses come in on a valid-only channel with no back-pressure: a response cycle is always consumed. The merged result leaves on a valid/ready channel. `out_valid_o` stays high, with its data unchanged, until `out_ready_i` accepts it, and the block is busy until then.

A stale-translation input can mark the access at any point while responses are still expected. The mark is dropped when the last response arrives. `LINE_BYTES` must be a power of two no smaller than 2.

Top module: `split_rsp_reassembler`

## Requirements
- R1: After reset, `busy_o`, `pkt_valid_o`, `out_valid_o`, `stale_o` and `err_o` are 0 and `out_data_o` is all zero.
- R2: A `start_i` pulse is accepted only when `busy_o` is 0 and `nfrag_i` is between 1 and `MAX_FRAGS`. An accepted pulse clears the merged buffer and all counts, and `busy_o` is 1 from the next cycle. Any other pulse has no effect.
- R3: The offered index `pkt_idx_o` equals the number of responses received plus the number of packets outstanding. Packets are therefore offered in order from index 0, and no index at or above the fragment count is ever offered.
- R4: A packet is offered only while the outstanding count is below the window. The window is `WINDOW` for an access of two or more fragments and 1 for a single-fragment access. Each cycle with `pkt_valid_o` and `pkt_ready_i` both high adds one to the outstanding count.
- R5: A refusal (valid high, ready low) makes `pkt_valid_o` low from the next cycle until the cycle after a `retry_i` pulse, when the same index is offered again. A `retry_i` pulse with no refusal pending has no effect.
- R6: A response is taken when `rsp_idx_i` is below the number of packets sent and that index has not been received yet. A taken response adds one to the received count and removes one from the outstanding count, which reopens the window.
- R7: Merged byte k (byte 0 in bits 7:0) is taken from lane (k + offset) mod `LINE_BYTES` of the response for fragment (k + offset) / `LINE_BYTES`. Lane j is bits 8j+7:8j of `rsp_data_i`. Bytes that no fragment covers stay zero.
- R8: A response that is not taken (a duplicate, an index not yet sent, or any response while idle) raises `err_o` for exactly the next cycle. It changes no data and no count.
- R9: `out_valid_o` rises in the cycle after the last response is taken. It stays high, with `out_data_o` stable, until `out_ready_i` is high, and `busy_o` falls in the next cycle.
- R10: `stale_set_i` sets `stale_o` from the next cycle while the block is busy and not complete. `start_i` clears it, and so does the taking of the last response, which wins over a `stale_set_i` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an access (pulse) |
| nfrag_i | input | $clog2(MAX_FRAGS+1) | Fragment count for the access |
| base_off_i | input | $clog2(LINE_BYTES) | Byte offset of the access base within its first line |
| pkt_valid_o | output | 1 | A fragment packet is offered |
| pkt_ready_i | input | 1 | Port accepts the offered packet; low with valid high is a refusal |
| pkt_idx_o | output | IW | Fragment index of the offered packet |
| retry_i | input | 1 | Port asks for the refused packet again (pulse) |
| rsp_valid_i | input | 1 | A response is present |
| rsp_idx_i | input | IW | Fragment index of the response |
| rsp_data_i | input | 8*LINE_BYTES | Line-aligned response data |
| stale_set_i | input | 1 | Mark the access as having a stale translation |
| stale_o | output | 1 | Stale-translation mark |
| err_o | output | 1 | Previous response was rejected |
| busy_o | output | 1 | An access is in progress |
| out_valid_o | output | 1 | Merged data is ready |
| out_ready_i | input | 1 | Consumer takes the merged data |
| out_data_o | output | 8*LINE_BYTES*MAX_FRAGS | Merged access data |

## Verification
Each access pattern is aimed at a different part of the send and merge logic. An unaligned three-fragment access with the port always ready tells a correct byte placement apart from one that is off by the base offset. A four-fragment access whose responses return out of order, with none returning for a while, separates a window that closes at `WINDOW` from one that does not. It also shows whether the window reopens from the received count. A single-fragment access checks the one-packet window. An access that starts with a refusal, together with a retry sent while nothing is blocked, shows whether the blocked state is entered and left only on the right events. Duplicates, indices not yet sent, responses while idle, and a stale mark in the same cycle as the final response probe the rejection and priority rules.

// File: rtl/split_rsp_pkg.sv
package split_rsp_pkg;

  // Send window for an access of nf fragments: one packet in flight when unsplit.
  function automatic int unsigned window_for(int unsigned nf, int unsigned split_win);
    return (nf == 1) ? 1 : split_win;
  endfunction

  // Fragment that supplies merged byte k for a given base offset.
  function automatic int unsigned src_frag(int unsigned k, int unsigned off, int unsigned line);
    return (k + off) / line;
  endfunction

endpackage

// File: rtl/split_rsp_send_window.sv
module split_rsp_send_window #(
  parameter int MAX_FRAGS = 4,
  parameter int WINDOW    = 2,
  localparam int CW = $clog2(MAX_FRAGS + 1),
  localparam int IW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic [CW-1:0] nfrag,
  input  logic [CW-1:0] rcv_cnt,
  input  logic          take,
  input  logic          pkt_ready,
  input  logic          retry,
  output logic          pkt_valid,
  output logic [IW-1:0] pkt_idx,
  output logic [CW-1:0] sent_cnt
);
  logic [CW-1:0] out_q;
  logic          blk_q;
  logic [CW-1:0] lim;
  logic          accept;

  always_comb begin
    lim       = CW'(split_rsp_pkg::window_for(int'(nfrag), WINDOW));
    sent_cnt  = rcv_cnt + out_q;
    pkt_valid = active && !blk_q && (sent_cnt < nfrag) && (out_q < lim);
    pkt_idx   = IW'(sent_cnt);
    accept    = pkt_valid && pkt_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      out_q <= '0;
      blk_q <= 1'b0;
    end else begin
      out_q <= out_q + CW'(accept) - CW'(take);
      if (blk_q) begin
        if (retry) blk_q <= 1'b0;
      end else if (pkt_valid && !pkt_ready) begin
        blk_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/split_rsp_track.sv
module split_rsp_track #(
  parameter int MAX_FRAGS = 4,
  localparam int CW = $clog2(MAX_FRAGS + 1),
  localparam int IW = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_idx,
  input  logic [CW-1:0] sent_cnt,
  output logic          take,
  output logic [CW-1:0] rcv_cnt,
  output logic          err
);
  logic [MAX_FRAGS-1:0] got_q;
  logic                 in_range;

  always_comb begin
    in_range = CW'(rsp_idx) < sent_cnt;
    take     = rsp_valid && active && in_range && !got_q[rsp_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_q   <= '0;
      rcv_cnt <= '0;
      err     <= 1'b0;
    end else begin
      err <= rsp_valid && !take;
      if (clear) begin
        got_q   <= '0;
        rcv_cnt <= '0;
      end else if (take) begin
        got_q[rsp_idx] <= 1'b1;
        rcv_cnt        <= rcv_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/split_rsp_merge.sv
module split_rsp_merge #(
  parameter int LINE_BYTES = 4,
  parameter int MAX_FRAGS  = 4,
  localparam int ACC = LINE_BYTES * MAX_FRAGS,
  localparam int LB  = $clog2(LINE_BYTES),
  localparam int SW  = $clog2(ACC + LINE_BYTES),
  localparam int IW  = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  logic [IW-1:0]           rsp_idx,
  input  logic [LB-1:0]           base_off,
  input  logic [8*LINE_BYTES-1:0] rsp_data,
  output logic [8*ACC-1:0]        merged
);
  logic [7:0] byte_q [ACC];

  for (genvar k = 0; k < ACC; k++) begin : g_byte
    logic [SW-1:0] pos;
    logic          hit;
    logic [7:0]    lane_byte;
    always_comb begin
      pos       = SW'(k) + SW'(base_off);
      hit       = take && (pos[SW-1:LB] == (SW-LB)'(rsp_idx));
      lane_byte = rsp_data[int'(pos[LB-1:0])*8 +: 8];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear) byte_q[k] <= 8'h00;
      else if (hit)        byte_q[k] <= lane_byte;
    end
    assign merged[k*8 +: 8] = byte_q[k];
  end
endmodule

// File: rtl/split_rsp_reassembler.sv
module split_rsp_reassembler #(
  parameter int LINE_BYTES = 4,
  parameter int MAX_FRAGS  = 4,
  parameter int WINDOW     = 2,
  localparam int CW  = $clog2(MAX_FRAGS + 1),
  localparam int IW  = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1,
  localparam int LB  = $clog2(LINE_BYTES),
  localparam int ACC = LINE_BYTES * MAX_FRAGS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [CW-1:0]           nfrag_i,
  input  logic [LB-1:0]           base_off_i,
  output logic                    pkt_valid_o,
  input  logic                    pkt_ready_i,
  output logic [IW-1:0]           pkt_idx_o,
  input  logic                    retry_i,
  input  logic                    rsp_valid_i,
  input  logic [IW-1:0]           rsp_idx_i,
  input  logic [8*LINE_BYTES-1:0] rsp_data_i,
  input  logic                    stale_set_i,
  output logic                    stale_o,
  output logic                    err_o,
  output logic                    busy_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [8*ACC-1:0]        out_data_o
);
  logic          busy_q, stale_q;
  logic [CW-1:0] nf_q;
  logic [LB-1:0] off_q;
  logic          start_ok, complete, take, last_take;
  logic [CW-1:0] rcv_cnt, sent_cnt;

  always_comb begin
    start_ok  = start_i && !busy_q && (nfrag_i != '0) && (nfrag_i <= CW'(MAX_FRAGS));
    complete  = busy_q && (rcv_cnt == nf_q);
    last_take = take && ((rcv_cnt + CW'(1)) == nf_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      nf_q    <= '0;
      off_q   <= '0;
    end else begin
      if (start_ok) begin
        busy_q <= 1'b1;
        nf_q   <= nfrag_i;
        off_q  <= base_off_i;
      end else if (complete && out_ready_i) begin
        busy_q <= 1'b0;
      end
      if (start_ok || last_take)                   stale_q <= 1'b0;
      else if (stale_set_i && busy_q && !complete) stale_q <= 1'b1;
    end
  end

  split_rsp_send_window #(.MAX_FRAGS(MAX_FRAGS), .WINDOW(WINDOW)) u_send (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .active(busy_q),
    .nfrag(nf_q), .rcv_cnt(rcv_cnt), .take(take),
    .pkt_ready(pkt_ready_i), .retry(retry_i),
    .pkt_valid(pkt_valid_o), .pkt_idx(pkt_idx_o), .sent_cnt(sent_cnt)
  );

  split_rsp_track #(.MAX_FRAGS(MAX_FRAGS)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .active(busy_q),
    .rsp_valid(rsp_valid_i), .rsp_idx(rsp_idx_i), .sent_cnt(sent_cnt),
    .take(take), .rcv_cnt(rcv_cnt), .err(err_o)
  );

  split_rsp_merge #(.LINE_BYTES(LINE_BYTES), .MAX_FRAGS(MAX_FRAGS)) u_merge (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .take(take),
    .rsp_idx(rsp_idx_i), .base_off(off_q), .rsp_data(rsp_data_i),
    .merged(out_data_o)
  );

  assign busy_o      = busy_q;
  assign stale_o     = stale_q;
  assign out_valid_o = complete;
endmodule

// File: rtl/split_rsp_reassembler_chk.sv
module split_rsp_reassembler_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pkt_valid_o,
  input logic              pkt_ready_i,
  input logic              rsp_valid_i,
  input logic              stale_o,
  input logic              err_o,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);
  a_r2_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !(out_valid_o && out_ready_i) |=> busy_o);

  a_r3_offer_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> busy_o && !out_valid_o);

  a_r5_refusal_drops: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=> !pkt_valid_o);

  a_r8_err_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(rsp_valid_i));

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r9_idle_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i |=> !busy_o);

  a_r10_stale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> !stale_o);
endmodule

bind split_rsp_reassembler split_rsp_reassembler_chk #(.DATA_W(8*LINE_BYTES*MAX_FRAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pkt_valid_o(pkt_valid_o),
  .pkt_ready_i(pkt_ready_i), .rsp_valid_i(rsp_valid_i), .stale_o(stale_o),
  .err_o(err_o), .busy_o(busy_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o)
);

// File: tb/split_rsp_reassembler_test.sv
module split_rsp_reassembler_test;
  localparam int LINE = 4, MAXF = 4, WIN = 2, ACC = LINE * MAXF;
  localparam int CW = 3, IW = 2, LB = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic start_i = 0, pkt_ready_i = 0, retry_i = 0, rsp_valid_i = 0;
  logic stale_set_i = 0, out_ready_i = 0;
  logic [CW-1:0] nfrag_i = '0;
  logic [LB-1:0] base_off_i = '0;
  logic [IW-1:0] rsp_idx_i = '0;
  logic [8*LINE-1:0] rsp_data_i = '0;
  logic pkt_valid_o, stale_o, err_o, busy_o, out_valid_o;
  logic [IW-1:0] pkt_idx_o;
  logic [8*ACC-1:0] out_data_o;

  split_rsp_reassembler #(.LINE_BYTES(LINE), .MAX_FRAGS(MAXF), .WINDOW(WIN)) uut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // Reference model state
  int m_busy = 0, m_nf = 0, m_off = 0, m_out = 0, m_rcv = 0, m_blk = 0, m_stale = 0, m_err = 0;
  bit m_got [MAXF];
  logic [7:0] m_buf [ACC];

  function automatic bit m_pv();
    int lim = (m_nf == 1) ? 1 : WIN;
    return m_busy != 0 && m_blk == 0 && (m_rcv + m_out) < m_nf && m_out < lim;
  endfunction

  function automatic bit m_ov();
    return m_busy != 0 && m_rcv == m_nf;
  endfunction

  function automatic logic [8*ACC-1:0] m_data();
    logic [8*ACC-1:0] d;
    for (int k = 0; k < ACC; k++) d[k*8 +: 8] = m_buf[k];
    return d;
  endfunction

  task automatic check(string sig, logic [8*ACC-1:0] act, logic [8*ACC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, sig, act, exp);
    end
  endtask

  task automatic compare_all();
    check("pkt_valid", 128'(pkt_valid_o), 128'(m_pv()));
    if (m_pv()) check("pkt_idx", 128'(pkt_idx_o), 128'(m_rcv + m_out));
    check("out_valid", 128'(out_valid_o), 128'(m_ov()));
    check("busy", 128'(busy_o), 128'(m_busy));
    check("stale", 128'(stale_o), 128'(m_stale));
    check("err", 128'(err_o), 128'(m_err));
    check("out_data", out_data_o, m_data());
  endtask

  task automatic model_step();
    bit pv = m_pv(), ov = m_ov();
    int sent = m_rcv + m_out;
    int idx = int'(rsp_idx_i);
    bit good = rsp_valid_i && m_busy != 0 && idx < sent && !m_got[idx];
    bit st_ok = start_i && m_busy == 0 && nfrag_i != 0 && int'(nfrag_i) <= MAXF;
    m_err = (rsp_valid_i && !good) ? 1 : 0;
    if (m_blk != 0) begin
      if (retry_i) m_blk = 0;
    end else if (pv && !pkt_ready_i) m_blk = 1;
    if (good && m_rcv + 1 == m_nf) m_stale = 0;
    else if (stale_set_i && m_busy != 0 && !ov) m_stale = 1;
    if (good) begin
      for (int k = 0; k < ACC; k++) begin
        int pos = k + m_off;
        if (pos / LINE == idx) m_buf[k] = rsp_data_i[(pos % LINE)*8 +: 8];
      end
      m_got[idx] = 1;
    end
    m_out = m_out + int'(pv && pkt_ready_i) - int'(good);
    m_rcv = m_rcv + int'(good);
    if (ov && out_ready_i) m_busy = 0;
    if (st_ok) begin
      m_busy = 1; m_nf = int'(nfrag_i); m_off = int'(base_off_i);
      m_out = 0; m_rcv = 0; m_blk = 0; m_stale = 0;
      for (int i = 0; i < MAXF; i++) m_got[i] = 0;
      for (int k = 0; k < ACC; k++) m_buf[k] = 8'h00;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    start_i = 0; retry_i = 0; rsp_valid_i = 0; stale_set_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic begin_access(int nf, int off);
    start_i = 1; nfrag_i = CW'(nf); base_off_i = LB'(off);
    tick();
  endtask

  task automatic respond(int idx, int seed);
    rsp_valid_i = 1; rsp_idx_i = IW'(idx);
    for (int l = 0; l < LINE; l++) rsp_data_i[l*8 +: 8] = 8'(seed*16 + idx*4 + l + 1);
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog cycles=%0d expected below %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAXF; i++) m_got[i] = 0;
    for (int k = 0; k < ACC; k++) m_buf[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    compare_all();

    // Unaligned three-fragment access, port always ready
    cur_req = "R3"; pkt_ready_i = 1; out_ready_i = 0;
    begin_access(3, 1); ticks(3);
    cur_req = "R6"; respond(0, 1); tick(); respond(1, 1); ticks(2);
    cur_req = "R7"; respond(2, 1); tick();
    out_ready_i = 1; tick(); out_ready_i = 0; tick();

    // Single fragment: one packet in flight, held result
    cur_req = "R4"; begin_access(1, 2); ticks(4); respond(0, 2);
    cur_req = "R9"; ticks(3); out_ready_i = 1; tick(); out_ready_i = 0; tick();

    // Four fragments, window closes, out-of-order returns
    cur_req = "R4"; begin_access(4, 0); ticks(4);
    cur_req = "R6"; respond(1, 3); tick(); respond(0, 3); ticks(2);
    respond(3, 3); respond(2, 3); tick(); out_ready_i = 1; tick(); out_ready_i = 0;

    // Refusal, blocked period, retry
    cur_req = "R5"; pkt_ready_i = 0; begin_access(4, 3); ticks(3);
    pkt_ready_i = 1; ticks(2); retry_i = 1; tick(); ticks(2);
    cur_req = "R8"; respond(0, 4); respond(0, 4); respond(3, 4); tick();
    cur_req = "R10"; stale_set_i = 1; tick(); respond(1, 4); ticks(2); respond(2, 4); tick();
    stale_set_i = 1; respond(3, 4);
    cur_req = "R5"; retry_i = 1; tick();
    cur_req = "R9"; out_ready_i = 1; tick(); out_ready_i = 0; tick();

    // Start pulses that must be ignored
    cur_req = "R2"; begin_access(0, 0); begin_access(5, 1);
    begin_access(2, 1); begin_access(3, 0); ticks(3);
    respond(0, 5); respond(1, 5); tick(); out_ready_i = 1; tick(); out_ready_i = 0;

    // Response while idle
    cur_req = "R8"; respond(1, 6); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule